// File: doc/BRIEF.md
# Load Stride Prefetch Engine

This block observes the stream of executed loads, one per cycle at most, and learns which load instructions walk through memory with a fixed step. Each load is identified by its program counter. A small direct-mapped history table remembers, per load, the previous address, the last observed step and a confidence level. Once a load has shown the same non-zero step twice in a row, every further matching execution emits a hardware prefetch request for the 64-byte line one step ahead. This happens whether or not the program contains any software prefetch instructions.

Requests leave the block as a one-cycle strobe with a line address. The block keeps its own record of which lines are still in flight to memory. It drops requests for lines already outstanding, and never allows more than eight in flight at once. A request blocked by that limit waits in a single hold slot until a completion returns. Completions name the line that has come back. The storage that receives prefetched data and the memory path are outside the block.

Top module: `stride_pf_engine`

## Requirements
- R1: While rst_n is low, and until the synchronised release two clock edges later, pf_valid is 0 and pf_inflight is 0. Reset invalidates every history entry, so the first load after reset produces no request.
- R2: The history table has 16 direct-mapped entries. The index is ld_pc[5:2] and the tag is all remaining PC bits. A load whose entry is empty or holds another tag takes over that entry in the init state with a stored step of 0 and issues nothing.
- R3: A load that hits an entry in the init state stores the observed step, ld_addr minus the stored address modulo 2^32. The entry moves to transient and issues nothing.
- R4: A load that hits a transient or steady entry whose stored step equals the observed non-zero step puts the entry in steady. In the next cycle pf_valid is 1 with pf_line = (ld_addr + step) >> 6, where negative steps are taken in two's complement. R7 to R9 still apply. pf_inflight then rises by one.
- R5: A hit whose observed step differs from the stored one leaves the entry transient with the new step stored, and issues nothing. The next matching access returns the entry to steady.
- R6: A step of zero never brings an entry to steady and never issues a request.
- R7: A steady load whose target address lies in the same 64-byte line as the load address (for example a step of 8) issues nothing.
- R8: A candidate whose line is already outstanding is dropped without a request. No two outstanding slots hold the same line.
- R9: At most eight requests are outstanding. A candidate found while eight are outstanding is held, and a newer blocked candidate replaces the held one. The held candidate issues in the cycle after a completion frees a slot.
- R10: done_valid with a done_line that matches an outstanding line retires it, and pf_inflight drops by one at the next edge. A done_line that matches nothing is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_valid | input | 1 | An executed load is presented this cycle |
| ld_pc | input | 32 | Program counter of the load |
| ld_addr | input | 32 | Byte address the load accessed |
| done_valid | input | 1 | A prefetched line has returned this cycle |
| done_line | input | 26 | Line address (byte address >> 6) of the returned line |
| pf_valid | output | 1 | One-cycle strobe: a prefetch request is issued |
| pf_line | output | 26 | Line address of the issued request |
| pf_inflight | output | 4 | Number of requests currently outstanding |

## Verification
A history entry left in the wrong confidence state shows up as a request one access early or one access late. That difference appears on pf_valid in the cycle after the deciding load, so each row of the stimulus table checks the strobe on that exact cycle. A stored step or last address that is off gives a wrong pf_line at the same point. Tracker faults show on pf_inflight one edge after an issue or a completion. A lost or duplicated slot also surfaces later, as a request that is wrongly suppressed, or a ninth request that escapes while eight are outstanding.

// File: rtl/spf_pkg.sv
package spf_pkg;
  typedef enum logic [1:0] {
    ST_INIT   = 2'd0,
    ST_TRANS  = 2'd1,
    ST_STEADY = 2'd2
  } conf_e;
endpackage

// File: rtl/spf_rst_sync.sv
module spf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/spf_stride_table.sv
module spf_stride_table
  import spf_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 4,
  parameter int LINE_OFS = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ld_valid,
  input  logic [PC_W-1:0]              ld_pc,
  input  logic [ADDR_W-1:0]            ld_addr,
  output logic                         req_fire,
  output logic [ADDR_W-LINE_OFS-1:0]   req_line
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W;

  logic [ENTRIES-1:0] ent_v;
  conf_e              ent_st     [ENTRIES];
  logic [TAG_W-1:0]   ent_tag    [ENTRIES];
  logic [ADDR_W-1:0]  ent_last   [ENTRIES];
  logic [ADDR_W-1:0]  ent_stride [ENTRIES];

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              hit;
  logic [ADDR_W-1:0] obs_stride;
  logic [ADDR_W-1:0] tgt_addr;
  logic              same_stride;
  logic              crosses;
  conf_e             st_nxt;
  logic [ADDR_W-1:0] stride_nxt;

  always_comb begin
    idx         = ld_pc[IDX_W+1:2];
    tag         = {ld_pc[PC_W-1:IDX_W+2], ld_pc[1:0]};
    hit         = ent_v[idx] && (ent_tag[idx] == tag);
    obs_stride  = ld_addr - ent_last[idx];
    same_stride = (obs_stride == ent_stride[idx]);
    tgt_addr    = ld_addr + obs_stride;
    crosses     = (tgt_addr[ADDR_W-1:LINE_OFS] != ld_addr[ADDR_W-1:LINE_OFS]);

    if (!hit)                                   st_nxt = ST_INIT;
    else if (ent_st[idx] == ST_INIT)            st_nxt = ST_TRANS;
    else if (same_stride && obs_stride != '0)   st_nxt = ST_STEADY;
    else                                        st_nxt = ST_TRANS;

    stride_nxt = hit ? obs_stride : '0;
    req_fire   = ld_valid && (st_nxt == ST_STEADY) && crosses;
    req_line   = tgt_addr[ADDR_W-1:LINE_OFS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v <= '0;
      for (int i = 0; i < ENTRIES; i++) ent_st[i] <= ST_INIT;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (ld_valid && idx == IDX_W'(i)) begin
          ent_v[i]  <= 1'b1;
          ent_st[i] <= st_nxt;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (ld_valid && idx == IDX_W'(i)) begin
        ent_tag[i]    <= tag;
        ent_last[i]   <= ld_addr;
        ent_stride[i] <= stride_nxt;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent_chk
    // R4
    steady_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_v[g] && ent_st[g] == ST_STEADY) |-> (ent_stride[g] != '0));
  end
endmodule

// File: rtl/spf_inflight_trk.sv
module spf_inflight_trk #(
  parameter int LINE_W  = 26,
  parameter int MAX_OUT = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_fire,
  input  logic [LINE_W-1:0]              req_line,
  input  logic                           done_valid,
  input  logic [LINE_W-1:0]              done_line,
  output logic                           pf_valid,
  output logic [LINE_W-1:0]              pf_line,
  output logic [$clog2(MAX_OUT+1)-1:0]   pf_inflight
);
  localparam int SLOT_W = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1;
  localparam int CNT_W  = $clog2(MAX_OUT + 1);

  logic [MAX_OUT-1:0] slot_v, slot_v_nxt;
  logic [LINE_W-1:0]  slot_line [MAX_OUT];
  logic               cand_v, cand_v_nxt;
  logic [LINE_W-1:0]  cand_line;
  logic [CNT_W-1:0]   cnt, cnt_nxt;

  logic [MAX_OUT-1:0] clr;
  logic               dup, full, issue, found;
  logic [SLOT_W-1:0]  free_idx;

  always_comb begin
    dup      = 1'b0;
    clr      = '0;
    found    = 1'b0;
    free_idx = '0;
    for (int i = 0; i < MAX_OUT; i++) begin
      if (slot_v[i] && slot_line[i] == cand_line) dup = 1'b1;
      clr[i] = done_valid && slot_v[i] && (slot_line[i] == done_line);
      if (!slot_v[i] && !found) begin
        found    = 1'b1;
        free_idx = SLOT_W'(i);
      end
    end
    full  = (cnt == CNT_W'(MAX_OUT));
    issue = cand_v && !dup && !full;

    for (int i = 0; i < MAX_OUT; i++)
      slot_v_nxt[i] = (slot_v[i] && !clr[i]) || (issue && free_idx == SLOT_W'(i));

    cnt_nxt    = cnt + CNT_W'(issue) - CNT_W'(|clr);
    cand_v_nxt = req_fire ? 1'b1 : ((issue || dup) ? 1'b0 : cand_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v <= '0;
      cand_v <= 1'b0;
      cnt    <= '0;
    end else begin
      slot_v <= slot_v_nxt;
      cand_v <= cand_v_nxt;
      cnt    <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (req_fire) cand_line <= req_line;
    for (int i = 0; i < MAX_OUT; i++)
      if (issue && free_idx == SLOT_W'(i)) slot_line[i] <= cand_line;
  end

  assign pf_valid    = issue;
  assign pf_line     = cand_line;
  assign pf_inflight = cnt;

  // R9
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_OUT));

  // R4
  issue_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !done_valid) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R10
  retire_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|clr) && !pf_valid) |=> (cnt == $past(cnt) - CNT_W'(1)));

  for (genvar a = 0; a < MAX_OUT; a++) begin : g_dup_a
    for (genvar b = a + 1; b < MAX_OUT; b++) begin : g_dup_b
      // R8
      no_dup_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(slot_v[a] && slot_v[b] && slot_line[a] == slot_line[b]));
    end
  end
endmodule

// File: rtl/stride_pf_engine.sv
module stride_pf_engine #(
  parameter int PC_W     = 32,
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 4,
  parameter int LINE_OFS = 6,
  parameter int MAX_OUT  = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ld_valid,
  input  logic [PC_W-1:0]                ld_pc,
  input  logic [ADDR_W-1:0]              ld_addr,
  input  logic                           done_valid,
  input  logic [ADDR_W-LINE_OFS-1:0]     done_line,
  output logic                           pf_valid,
  output logic [ADDR_W-LINE_OFS-1:0]     pf_line,
  output logic [$clog2(MAX_OUT+1)-1:0]   pf_inflight
);
  localparam int LINE_W = ADDR_W - LINE_OFS;

  logic              rst_n_i;
  logic              req_fire;
  logic [LINE_W-1:0] req_line;

  spf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  spf_stride_table #(
    .PC_W     (PC_W),
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W),
    .LINE_OFS (LINE_OFS)
  ) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .ld_valid (ld_valid),
    .ld_pc    (ld_pc),
    .ld_addr  (ld_addr),
    .req_fire (req_fire),
    .req_line (req_line)
  );

  spf_inflight_trk #(
    .LINE_W  (LINE_W),
    .MAX_OUT (MAX_OUT)
  ) u_trk (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .req_fire    (req_fire),
    .req_line    (req_line),
    .done_valid  (done_valid),
    .done_line   (done_line),
    .pf_valid    (pf_valid),
    .pf_line     (pf_line),
    .pf_inflight (pf_inflight)
  );
endmodule

// File: tb/stride_pf_engine_tb_top.sv
module stride_pf_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_pc = '0;
  logic [31:0] ld_addr = '0;
  logic        done_valid = 1'b0;
  logic [25:0] done_line = '0;
  logic        pf_valid;
  logic [25:0] pf_line;
  logic [3:0]  pf_inflight;

  int checks = 0;
  int errors = 0;

  always #5ns clk = ~clk;

  stride_pf_engine dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_valid    (ld_valid),
    .ld_pc       (ld_pc),
    .ld_addr     (ld_addr),
    .done_valid  (done_valid),
    .done_line   (done_line),
    .pf_valid    (pf_valid),
    .pf_line     (pf_line),
    .pf_inflight (pf_inflight)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] addr;
    logic        pf;
    logic [25:0] line;
    logic [3:0]  cnt;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 23;
  localparam vec_t VECS [NVEC] = '{
    '{32'h1000, 32'h10000, 1'b0, 26'h0,   4'd0, 4'd2},  // R2 allocate A
    '{32'h1000, 32'h10040, 1'b0, 26'h0,   4'd0, 4'd3},  // R3 transient
    '{32'h1000, 32'h10080, 1'b1, 26'h403, 4'd1, 4'd4},  // R4 steady, issue
    '{32'h1000, 32'h100C0, 1'b1, 26'h404, 4'd2, 4'd4},  // R4 keeps issuing
    '{32'h1000, 32'h10200, 1'b0, 26'h0,   4'd2, 4'd5},  // R5 mismatch demotes
    '{32'h1000, 32'h10340, 1'b1, 26'h412, 4'd3, 4'd5},  // R5 back to steady
    '{32'h2004, 32'h03000, 1'b0, 26'h0,   4'd3, 4'd2},  // R2 allocate B
    '{32'h2004, 32'h03000, 1'b0, 26'h0,   4'd3, 4'd3},  // R3 zero step stored
    '{32'h2004, 32'h03000, 1'b0, 26'h0,   4'd3, 4'd6},  // R6 zero step never steady
    '{32'h3008, 32'h05000, 1'b0, 26'h0,   4'd3, 4'd2},  // R2 allocate C
    '{32'h3008, 32'h05008, 1'b0, 26'h0,   4'd3, 4'd3},  // R3 small step
    '{32'h3008, 32'h05010, 1'b0, 26'h0,   4'd3, 4'd7},  // R7 same line
    '{32'h3008, 32'h05018, 1'b0, 26'h0,   4'd3, 4'd7},  // R7 same line
    '{32'h400C, 32'h09000, 1'b0, 26'h0,   4'd3, 4'd2},  // R2 allocate D
    '{32'h400C, 32'h08F00, 1'b0, 26'h0,   4'd3, 4'd3},  // R3 negative step
    '{32'h400C, 32'h08E00, 1'b1, 26'h234, 4'd4, 4'd4},  // R4 negative step issues
    '{32'h1040, 32'h20000, 1'b0, 26'h0,   4'd4, 4'd2},  // R2 alias evicts A
    '{32'h1000, 32'h10380, 1'b0, 26'h0,   4'd4, 4'd2},  // R2 A misses again
    '{32'h1000, 32'h103C0, 1'b0, 26'h0,   4'd4, 4'd3},  // R3 A transient
    '{32'h400C, 32'h08D00, 1'b1, 26'h230, 4'd5, 4'd4},  // R4 D continues
    '{32'h5010, 32'h10000, 1'b0, 26'h0,   4'd5, 4'd2},  // R2 allocate F
    '{32'h5010, 32'h10040, 1'b0, 26'h0,   4'd5, 4'd3},  // R3 F transient
    '{32'h5010, 32'h10080, 1'b0, 26'h0,   4'd5, 4'd8}   // R8 line 0x403 outstanding
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(logic [31:0] pc, logic [31:0] addr);
    ld_pc    = pc;
    ld_addr  = addr;
    ld_valid = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic do_done(logic [25:0] line);
    done_line  = line;
    done_valid = 1'b1;
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs held during reset
    check("R1 pf_valid in reset", 32'(pf_valid), 32'd0);
    check("R1 inflight in reset", 32'(pf_inflight), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 pf_valid after release", 32'(pf_valid), 32'd0);

    for (int k = 0; k < NVEC; k++) begin
      do_load(VECS[k].pc, VECS[k].addr);
      check($sformatf("R%0d row %0d pf_valid", VECS[k].req, k), 32'(pf_valid), 32'(VECS[k].pf));
      if (VECS[k].pf)
        check($sformatf("R%0d row %0d pf_line", VECS[k].req, k), 32'(pf_line), 32'(VECS[k].line));
      @(negedge clk);
      check($sformatf("R%0d row %0d inflight", VECS[k].req, k), 32'(pf_inflight), 32'(VECS[k].cnt));
    end

    // R10 matching completion retires, unmatched one ignored
    do_done(26'h403);
    check("R10 retire matched", 32'(pf_inflight), 32'd4);
    do_done(26'h0777);
    check("R10 unmatched ignored", 32'(pf_inflight), 32'd4);

    // R9 fill to eight with stream D (step -0x100)
    do_load(32'h400C, 32'h8C00);
    check("R4 fill 5 line", 32'(pf_line), 32'h22C);
    do_load(32'h400C, 32'h8B00);
    check("R4 fill 6 line", 32'(pf_line), 32'h228);
    do_load(32'h400C, 32'h8A00);
    check("R4 fill 7 line", 32'(pf_line), 32'h224);
    do_load(32'h400C, 32'h8900);
    check("R4 fill 8 valid", 32'(pf_valid), 32'd1);
    check("R4 fill 8 line", 32'(pf_line), 32'h220);
    do_load(32'h400C, 32'h8800);
    check("R9 blocked at cap", 32'(pf_valid), 32'd0);
    check("R9 count at cap", 32'(pf_inflight), 32'd8);
    do_load(32'h400C, 32'h8700);
    check("R9 second blocked", 32'(pf_valid), 32'd0);
    @(negedge clk);
    check("R9 still waiting", 32'(pf_valid), 32'd0);
    do_done(26'h404);
    check("R9 held issues after free", 32'(pf_valid), 32'd1);
    check("R9 newer candidate replaced held", 32'(pf_line), 32'h218);
    check("R10 count after retire", 32'(pf_inflight), 32'd7);
    @(negedge clk);
    check("R9 single strobe", 32'(pf_valid), 32'd0);
    check("R9 back at cap", 32'(pf_inflight), 32'd8);

    // R1 reset mid-run clears tracker and table
    rst_n = 1'b0;
    #1ns;
    check("R1 async pf_valid", 32'(pf_valid), 32'd0);
    check("R1 async inflight", 32'(pf_inflight), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_load(32'h400C, 32'h8600);
    check("R1 table cleared, no request", 32'(pf_valid), 32'd0);
    do_load(32'h400C, 32'h8500);
    check("R3 relearn after reset", 32'(pf_valid), 32'd0);
    @(negedge clk);
    check("R1 inflight stays zero", 32'(pf_inflight), 32'd0);

    finish_run();
  end
endmodule